// File: doc/BRIEF.md
# Quarter-Wave Cosine Table Expander

The block produces every sample of one cosine period while only the first quarter of that period is held in memory. A phase index arrives with a strobe. The block reduces the index modulo the selected period length and folds it onto the stored quarter. It then reads the word from its internal table and negates the word when the index lies in the second or third quarter. The signed sample leaves one clock later with its own strobe.

The quarter table holds N/4+1 words, so both the zero-phase peak and the quarter-phase crossing are stored. It is loaded through a plain write port before lookups start. The caller chooses the period length at run time with a 3-bit resolution code, from 128 up to 4096 points per cycle. The six legal sizes use 33, 65, 129, 257, 513 or 1025 table words.

Top module: `cos_quarter_expander`

## Requirements
- R1: After reset `out_valid` and `out_err` are 0, `out_sample` is 0, and the active resolution is code 000 (128 points).
- R2: With Q = N/4 and k the reduced index, an index with k ≤ Q returns table word T[k] unchanged.
- R3: An index with Q < k ≤ 2Q returns −T[2Q−k].
- R4: An index with 2Q < k ≤ 3Q returns −T[k−2Q].
- R5: An index with 3Q < k < 4Q returns T[4Q−k].
- R6: `res_sel` code c in 0..5 selects N = 128·2^c points. The code is registered, so a new code governs lookups strobed from the following clock onward.
- R7: Under code 110 or 111, a strobed lookup gives `out_valid`=1, `out_err`=1 and `out_sample`=0. Under a legal code, `out_err` stays 0.
- R8: Index bits at and above log2(N) are ignored, so the phase wraps modulo N.
- R9: `out_valid` is high exactly in the cycle after a cycle with `idx_valid` high. `out_sample` is 0 whenever `out_valid` is low.
- R10: Negation saturates: a stored word of 0x800000 read in a negated quarter yields 0x7FFFFF.
- R11: A table write with `wr_addr` above 1024 changes no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_sel | input | 3 | Resolution code, points = 128·2^code for codes 0..5 |
| idx | input | 12 | Phase index |
| idx_valid | input | 1 | Lookup strobe for `idx` |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 11 | Table write address, 0..1024 valid |
| wr_data | input | 24 | Signed table word |
| out_sample | output | 24 | Signed cosine sample |
| out_valid | output | 1 | Sample strobe, one clock after `idx_valid` |
| out_err | output | 1 | Lookup made under an illegal resolution code |

## Verification
The hardest case to reach is saturating negation. A smooth quarter cosine never stores the most negative code, so the stimulus first overwrites one table word with 0x800000. It then strobes indices that fold onto that word from both negated quarters. The quarter-boundary indices k = Q, 2Q and 3Q are also hit at every legal resolution, because each belongs to a different fold rule and an off-by-one in the comparisons shows up only there. Every index of the 128-point period is swept against a model of the fold rules.

// File: rtl/cqx_pkg.sv
package cqx_pkg;
    localparam int CQX_DATA_W   = 24;
    localparam int CQX_RES_W    = 3;
    localparam int CQX_BASE_LOG = 7;
    localparam int CQX_MAX_CODE = 5;

    typedef struct packed {
        logic                 vld;
        logic                 neg;
        logic                 err;
        logic [CQX_RES_W-1:0] res;
    } cqx_state_t;
endpackage

// File: rtl/cqx_index_map.sv
module cqx_index_map #(
    parameter int IDX_W    = 12,
    parameter int ADDR_W   = 11,
    parameter int RES_W    = 3,
    parameter int BASE_LOG = 7,
    parameter int MAX_CODE = 5
) (
    input  logic [RES_W-1:0]  res,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr,
    output logic              neg,
    output logic              bad_res
);
    localparam int KW = IDX_W + 1;

    logic [KW-1:0] n_pts;
    logic [KW-1:0] q;
    logic [KW-1:0] k;
    logic [KW-1:0] a_full;

    always_comb begin
        bad_res = (res > RES_W'(MAX_CODE));
        n_pts   = KW'(1 << BASE_LOG) << res;
        q       = n_pts >> 2;
        k       = {1'b0, idx} & (n_pts - KW'(1));
        if (k <= q) begin
            a_full = k;
            neg    = 1'b0;
        end else if (k <= (q << 1)) begin
            a_full = (q << 1) - k;
            neg    = 1'b1;
        end else if (k <= (q << 1) + q) begin
            a_full = k - (q << 1);
            neg    = 1'b1;
        end else begin
            a_full = (q << 2) - k;
            neg    = 1'b0;
        end
        addr = a_full[ADDR_W-1:0];
    end
endmodule

// File: rtl/cqx_table_ram.sv
module cqx_table_ram #(
    parameter int DATA_W = 24,
    parameter int ADDR_W = 11,
    parameter int DEPTH  = 1025
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we && (waddr < ADDR_W'(DEPTH))) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata_q <= mem[raddr];
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/cqx_sign_stage.sv
module cqx_sign_stage #(
    parameter int DATA_W = 24
) (
    input  logic [DATA_W-1:0] word,
    input  logic              neg,
    input  logic              vld,
    input  logic              err,
    output logic [DATA_W-1:0] sample
);
    localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] MOST_POS = {1'b0, {(DATA_W-1){1'b1}}};

    logic [DATA_W-1:0] flipped;

    always_comb begin
        flipped = (word == MOST_NEG) ? MOST_POS : (~word + DATA_W'(1));
        if (!vld || err) begin
            sample = '0;
        end else begin
            sample = neg ? flipped : word;
        end
    end
endmodule

// File: rtl/cos_quarter_expander.sv
module cos_quarter_expander
    import cqx_pkg::*;
#(
    parameter int DATA_W   = CQX_DATA_W,
    parameter int RES_W    = CQX_RES_W,
    parameter int BASE_LOG = CQX_BASE_LOG,
    parameter int MAX_CODE = CQX_MAX_CODE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RES_W-1:0]  res_sel,
    input  logic [BASE_LOG+MAX_CODE-1:0] idx,
    input  logic              idx_valid,
    input  logic              wr_en,
    input  logic [$clog2((1 << (BASE_LOG+MAX_CODE-2)) + 1)-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] out_sample,
    output logic              out_valid,
    output logic              out_err
);
    localparam int IDX_W  = BASE_LOG + MAX_CODE;
    localparam int DEPTH  = (1 << (IDX_W - 2)) + 1;
    localparam int ADDR_W = $clog2(DEPTH);

    cqx_state_t st_d, st_q;

    logic [ADDR_W-1:0] rd_addr;
    logic              map_neg;
    logic              map_bad;
    logic [DATA_W-1:0] rd_word;

    cqx_index_map #(
        .IDX_W(IDX_W), .ADDR_W(ADDR_W), .RES_W(RES_W),
        .BASE_LOG(BASE_LOG), .MAX_CODE(MAX_CODE)
    ) u_map (
        .res(st_q.res), .idx(idx), .addr(rd_addr),
        .neg(map_neg), .bad_res(map_bad)
    );

    cqx_table_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_ram (
        .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
        .re(idx_valid && !map_bad), .raddr(rd_addr), .rdata(rd_word)
    );

    always_comb begin
        st_d     = st_q;
        st_d.res = res_sel;
        st_d.vld = idx_valid;
        st_d.neg = idx_valid ? map_neg : 1'b0;
        st_d.err = idx_valid && map_bad;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    cqx_sign_stage #(.DATA_W(DATA_W)) u_sign (
        .word(rd_word), .neg(st_q.neg), .vld(st_q.vld),
        .err(st_q.err), .sample(out_sample)
    );

    assign out_valid = st_q.vld;
    assign out_err   = st_q.err;
endmodule

// File: rtl/cqx_chk.sv
module cqx_chk #(
    parameter int DATA_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              idx_valid,
    input logic              out_valid,
    input logic              out_err,
    input logic [DATA_W-1:0] out_sample
);
    // R9
    strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_valid |=> out_valid);

    // R9
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(idx_valid));

    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_sample == '0));

    // R7
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (out_valid && out_sample == '0));
endmodule

bind cos_quarter_expander cqx_chk #(.DATA_W(DATA_W)) u_cqx_chk (
    .clk(clk), .rst_n(rst_n), .idx_valid(idx_valid),
    .out_valid(out_valid), .out_err(out_err), .out_sample(out_sample)
);

// File: tb/cos_quarter_expander_bench.sv
module cos_quarter_expander_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  res_sel = 3'd0;
    logic [11:0] idx = '0;
    logic        idx_valid = 1'b0;
    logic        wr_en = 1'b0;
    logic [10:0] wr_addr = '0;
    logic [23:0] wr_data = '0;
    logic [23:0] out_sample;
    logic        out_valid;
    logic        out_err;

    int n_run = 0;
    int n_fail = 0;
    logic [23:0] tbl [1025];

    always #2.5 clk = ~clk;

    cos_quarter_expander u_cos_quarter_expander (
        .clk(clk), .rst_n(rst_n), .res_sel(res_sel), .idx(idx),
        .idx_valid(idx_valid), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .out_sample(out_sample),
        .out_valid(out_valid), .out_err(out_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] model(input int k_in, input int code);
        int n, q, k, a;
        logic neg;
        logic [23:0] v;
        if (code > 5) return 24'd0;
        n = 128 << code;
        q = n / 4;
        k = k_in % n;
        if (k <= q)          begin a = k;         neg = 1'b0; end
        else if (k <= 2 * q) begin a = 2 * q - k; neg = 1'b1; end
        else if (k <= 3 * q) begin a = k - 2 * q; neg = 1'b1; end
        else                 begin a = 4 * q - k; neg = 1'b0; end
        v = tbl[a];
        if (neg) v = (v == 24'h800000) ? 24'h7FFFFF : (~v + 24'd1);
        return v;
    endfunction

    task automatic write_word(input int a, input logic [23:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 11'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_res(input int code);
        @(negedge clk);
        res_sel = 3'(code);
        @(negedge clk);
    endtask

    task automatic lookup(input string req, input int k, input int code);
        @(negedge clk);
        idx = 12'(k); idx_valid = 1'b1;
        @(negedge clk);
        idx_valid = 1'b0;
        check(req, {31'd0, out_valid}, 32'd1);
        check(req, {8'd0, out_sample}, {8'd0, model(k, code)});
        check(req, {31'd0, out_err}, {31'd0, (code > 5)});
    endtask

    task automatic t_reset;
        check("R1", {31'd0, out_valid}, 32'd0);
        check("R1", {31'd0, out_err}, 32'd0);
        check("R1", {8'd0, out_sample}, 32'd0);
    endtask

    task automatic t_load;
        for (int a = 0; a < 1025; a++) begin
            tbl[a] = 24'(a * 7919 - 4000000);
            write_word(a, tbl[a]);
        end
    endtask

    task automatic t_default_res;
        // R1: no res_sel change yet, so 128 points apply
        lookup("R1", 33, 0);
        lookup("R1", 100, 0);
    endtask

    task automatic t_sweep128;
        for (int k = 0; k < 128; k++) begin
            if (k <= 32)      lookup("R2", k, 0);
            else if (k <= 64) lookup("R3", k, 0);
            else if (k <= 96) lookup("R4", k, 0);
            else              lookup("R5", k, 0);
        end
    endtask

    task automatic t_resolutions;
        for (int c = 1; c <= 5; c++) begin
            int q;
            q = 32 << c;
            set_res(c);
            lookup("R6", 0, c);
            lookup("R2", q, c);
            lookup("R3", q + 1, c);
            lookup("R3", 2 * q, c);
            lookup("R4", 2 * q + 1, c);
            lookup("R4", 3 * q, c);
            lookup("R5", 3 * q + 1, c);
            lookup("R5", 4 * q - 1, c);
        end
    endtask

    task automatic t_wrap;
        set_res(0);
        lookup("R8", 128 * 5 + 7, 0);
        lookup("R8", 4095, 0);
        set_res(2);
        lookup("R8", 512 * 3 + 300, 2);
    endtask

    task automatic t_invalid;
        set_res(6);
        lookup("R7", 10, 6);
        set_res(7);
        lookup("R7", 77, 7);
        set_res(0);
        lookup("R7", 10, 0);
    endtask

    task automatic t_latency;
        @(negedge clk);
        idx = 12'd3; idx_valid = 1'b1;
        check("R9", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        idx_valid = 1'b0;
        check("R9", {31'd0, out_valid}, 32'd1);
        @(negedge clk);
        check("R9", {31'd0, out_valid}, 32'd0);
        check("R9", {8'd0, out_sample}, 32'd0);
    endtask

    task automatic t_saturate;
        set_res(0);
        tbl[5] = 24'h800000;
        write_word(5, 24'h800000);
        lookup("R10", 64 - 5, 0);
        lookup("R10", 64 + 5, 0);
        check("R10", {8'd0, model(69, 0)}, 32'h007FFFFF);
        lookup("R10", 5, 0);
    endtask

    task automatic t_oob_write;
        write_word(1025, 24'h123456);
        write_word(1537, 24'h654321);
        write_word(2047, 24'h0F0F0F);
        set_res(0);
        lookup("R11", 1, 0);
        lookup("R11", 0, 0);
        set_res(5);
        lookup("R11", 1024, 5);
    endtask

    initial begin
        #1;
        t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load();
        t_default_res();
        t_sweep128();
        t_resolutions();
        t_wrap();
        t_invalid();
        t_latency();
        t_saturate();
        t_oob_write();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule